// File: doc/BRIEF.md
# Word-Serial SPI Master Engine

This block is the serial core of an SPI master. It takes 32-bit words from an output word stream, shifts a programmable number of bits (4 to 32) out on MOSI most significant bit first, and at the same time collects the same number of bits from MISO. Each received word goes to an input word stream. Transmit data is taken from the top of the 32-bit word downward. Received data is returned right-justified, with zeros above the word length.

A transfer begins with a one-cycle `start`. The engine latches the configuration at that point and runs for a programmed number of words. It holds the selected chip select low for the whole transfer and then raises a sticky `done` flag. Serial clock timing is set from outside by `spi_tick`: every tick moves SCLK by one half period.

Configuration inputs set the following:
- the SCLK idle level;
- whether data is captured on the leading or the trailing edge;
- an internal loopback from MOSI to the receive path;
- transmit-only and receive-only operation;
- which of the chip selects is used, and forcing that chip select low while idle.

An empty output stream at a word boundary stalls the engine and reports an underrun. A receive side that is not ready when a word completes causes an overrun report, and that word is dropped.

Top module: `spi_word_engine`

## Requirements
- R1: After reset, all `cs_n` lines are 1, `sclk` is 0, and `busy`, `done`, `rx_valid` and `tx_ready` are 0.
- R2: The word length is `cfg_len_m1`+1 bits. Values of `cfg_len_m1` below 3 give 4-bit words. Each word makes exactly two SCLK transitions per bit.
- R3: Transmit bits go out MSB first, starting at `tx_data[31]` and moving downward. In loopback with the transmit side enabled, each received word equals the transmitted word shifted right by (32 − length).
- R4: Without loopback, received bits come from `miso` MSB first. They are placed right-justified in `rx_data`, and all bits above the word length read 0.
- R5: With `cfg_capture_first`=1, the first bit is on MOSI before the leading edge, and data is sampled on the leading edge. With 0, data changes on the leading edge and is sampled on the trailing edge. Both settings return correct words.
- R6: Between transfers, and while stalled, `sclk` rests at `cfg_idle_high`. During shifting, the leading edge moves it away from that level.
- R7: During a transfer, only `cs_n[cfg_cs_sel]` is 0. When the engine is idle, `cfg_force_cs`=1 drives that same line to 0.
- R8: After `cfg_word_count` words, `busy` falls, `done` rises and stays set until the next `start`, and `cs_n` returns to all ones. A start with a count of 0 sets `done` at once and asserts no chip select.
- R9: With `cfg_no_tx`=1, `tx_ready` stays 0, no output word is consumed, and MOSI carries zeros.
- R10: With `cfg_no_rx`=1, the transfer runs to completion but `rx_valid` is never asserted.
- R11: If no output word is valid at a word boundary, `tx_underrun` pulses once for that stall. SCLK then holds its idle level until a word arrives, after which the transfer continues.
- R12: A word that completes while `rx_ready` is 0 is dropped. In that case `rx_overrun` pulses once, `rx_valid` stays 0, and the transfer continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_tick | input | 1 | Half-period enable for SCLK |
| start | input | 1 | Begin a transfer when idle |
| cfg_len_m1 | input | 5 | Word length minus one |
| cfg_capture_first | input | 1 | 1: sample on leading edge |
| cfg_loopback | input | 1 | Feed MOSI back into the receive path |
| cfg_no_tx | input | 1 | Send zeros, consume no output words |
| cfg_no_rx | input | 1 | Discard received words |
| cfg_idle_high | input | 1 | SCLK idle level |
| cfg_force_cs | input | 1 | Hold selected chip select low |
| cfg_cs_sel | input | 2 | Chip select index |
| cfg_word_count | input | 16 | Words per transfer |
| tx_data | input | 32 | Output word, left-justified |
| tx_valid | input | 1 | Output word valid |
| tx_ready | output | 1 | Engine takes the output word |
| rx_data | output | 32 | Received word, right-justified |
| rx_valid | output | 1 | One-cycle received word strobe |
| rx_ready | input | 1 | Receiver can take a word |
| tx_underrun | output | 1 | Stall pulse on empty output stream |
| rx_overrun | output | 1 | Dropped-word pulse |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
Loopback runs with varied words at lengths of 4 (clamped), 8 and 32 bits, in both capture phases and at both idle levels. Their results separate a wrong bit order, a wrong justification and an off-by-one in the edge count. External MISO held at 1 and at 0 with loopback off separates the MISO path from the loopback path, and it also shows whether the upper bits are masked. Further runs cover the one-directional settings, a withheld output word, a receiver that is not ready, a zero count and a forced chip select. Each of these probes a path that the plain transfers never take.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

  localparam int MIN_BITS = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2
  } eng_state_t;

  typedef struct packed {
    logic cap_first;
    logic loopback;
    logic no_tx;
    logic no_rx;
    logic idle_high;
  } xfer_mode_t;

endpackage

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              lead,
  input  logic              trail,
  input  logic              last,
  input  logic              cap_first,
  input  logic              loopback,
  input  logic [DATA_W-1:0] load_word,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic              sample_bit;
  logic [DATA_W-1:0] rx_next;

  assign sample_bit = loopback ? mosi : miso;
  assign rx_next    = {rx_sh[DATA_W-2:0], sample_bit};
  // Leading-edge capture has all bits in rx_sh already; trailing-edge
  // capture still needs the bit sampled at the final edge.
  assign rx_word    = cap_first ? rx_sh : rx_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
      rx_sh <= '0;
      mosi  <= 1'b0;
    end else if (load) begin
      rx_sh <= '0;
      if (cap_first) begin
        mosi  <= load_word[DATA_W-1];
        tx_sh <= {load_word[DATA_W-2:0], 1'b0};
      end else begin
        tx_sh <= load_word;
      end
    end else if (lead) begin
      if (cap_first) begin
        rx_sh <= rx_next;
      end else begin
        mosi  <= tx_sh[DATA_W-1];
        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
    end else if (trail) begin
      if (!cap_first) begin
        rx_sh <= rx_next;
      end else if (!last) begin
        mosi  <= tx_sh[DATA_W-1];
        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spi_cs_select.sv
module spi_cs_select #(
  parameter int NUM_CS = 4,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             force_on,
  input  logic [SEL_W-1:0] sel,
  output logic [NUM_CS-1:0] cs_n
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) cs_n[i] <= 1'b1;
      else     cs_n[i] <= !((active || force_on) && (sel == SEL_W'(i)));
    end
  end

endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
  import spi_word_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 16,
  localparam int LEN_W = $clog2(DATA_W),
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_tick,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic              cfg_capture_first,
  input  logic              cfg_loopback,
  input  logic              cfg_no_tx,
  input  logic              cfg_no_rx,
  input  logic              cfg_idle_high,
  input  logic              cfg_force_cs,
  input  logic [SEL_W-1:0]  cfg_cs_sel,
  input  logic [CNT_W-1:0]  cfg_word_count,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              tx_underrun,
  output logic              rx_overrun,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);

  localparam logic [LEN_W-1:0] MIN_M1 = LEN_W'(MIN_BITS - 1);

  eng_state_t        state;
  xfer_mode_t        mode_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  len_eff;
  logic [LEN_W-1:0]  bitcnt;
  logic [CNT_W-1:0]  wcnt;
  logic [CNT_W-1:0]  count_q;
  logic [SEL_W-1:0]  sel_q;
  logic              ph;
  logic              sclk_q;
  logic              done_q;
  logic              stall_q;
  logic              rxv_q;
  logic              ovr_q;
  logic              und_q;
  logic [DATA_W-1:0] rxd_q;

  logic              load;
  logic              lead;
  logic              trail;
  logic              bit_last;
  logic [DATA_W-1:0] load_word;
  logic [DATA_W-1:0] rx_word;

  assign len_eff   = (cfg_len_m1 < MIN_M1) ? MIN_M1 : cfg_len_m1;
  assign load      = (state == ST_LOAD) && (mode_q.no_tx || tx_valid);
  assign load_word = mode_q.no_tx ? '0 : tx_data;
  assign lead      = (state == ST_SHIFT) && spi_tick && !ph;
  assign trail     = (state == ST_SHIFT) && spi_tick && ph;
  assign bit_last  = (bitcnt == len_q);

  assign tx_ready    = (state == ST_LOAD) && !mode_q.no_tx;
  assign busy        = (state != ST_IDLE);
  assign done        = done_q;
  assign sclk        = sclk_q;
  assign rx_valid    = rxv_q;
  assign rx_data     = rxd_q;
  assign rx_overrun  = ovr_q;
  assign tx_underrun = und_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mode_q  <= '0;
      len_q   <= MIN_M1;
      bitcnt  <= '0;
      wcnt    <= '0;
      count_q <= '0;
      sel_q   <= '0;
      ph      <= 1'b0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
      stall_q <= 1'b0;
      rxv_q   <= 1'b0;
      ovr_q   <= 1'b0;
      und_q   <= 1'b0;
      rxd_q   <= '0;
    end else begin
      rxv_q <= 1'b0;
      ovr_q <= 1'b0;
      und_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          sclk_q <= cfg_idle_high;
          sel_q  <= cfg_cs_sel;
          if (start) begin
            if (cfg_word_count == '0) begin
              done_q <= 1'b1;
            end else begin
              done_q  <= 1'b0;
              state   <= ST_LOAD;
              len_q   <= len_eff;
              mode_q  <= '{cap_first: cfg_capture_first, loopback: cfg_loopback,
                           no_tx: cfg_no_tx, no_rx: cfg_no_rx,
                           idle_high: cfg_idle_high};
              count_q <= cfg_word_count;
              wcnt    <= '0;
              stall_q <= 1'b0;
            end
          end
        end
        ST_LOAD: begin
          sclk_q <= mode_q.idle_high;
          if (load) begin
            state   <= ST_SHIFT;
            ph      <= 1'b0;
            bitcnt  <= '0;
            stall_q <= 1'b0;
          end else if (!stall_q) begin
            und_q   <= 1'b1;
            stall_q <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (spi_tick) begin
            if (!ph) begin
              ph     <= 1'b1;
              sclk_q <= ~mode_q.idle_high;
            end else begin
              ph     <= 1'b0;
              sclk_q <= mode_q.idle_high;
              if (bit_last) begin
                if (!mode_q.no_rx) begin
                  if (rx_ready) begin
                    rxv_q <= 1'b1;
                    rxd_q <= rx_word;
                  end else begin
                    ovr_q <= 1'b1;
                  end
                end
                if (wcnt == count_q - 1'b1) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
                end else begin
                  wcnt  <= wcnt + 1'b1;
                  state <= ST_LOAD;
                end
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  spi_word_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .lead      (lead),
    .trail     (trail),
    .last      (bit_last),
    .cap_first (mode_q.cap_first),
    .loopback  (mode_q.loopback),
    .load_word (load_word),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

  spi_cs_select #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
    .clk      (clk),
    .rst      (rst),
    .active   (busy),
    .force_on (cfg_force_cs),
    .sel      (sel_q),
    .cs_n     (cs_n)
  );

endmodule

// File: rtl/spi_word_engine_chk.sv
module spi_word_engine_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              sclk,
  input logic [NUM_CS-1:0] cs_n,
  input logic              tx_valid,
  input logic              tx_underrun,
  input logic              rx_valid,
  input logic              rx_overrun,
  input logic              cfg_idle_high
);

  assert_cs_single_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1);

  assert_sclk_with_cs_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && busy && (sclk != $past(sclk))) |-> (cs_n != '1));

  assert_idle_level_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !busy && $past(!busy) && $stable(cfg_idle_high))
      |-> (sclk == cfg_idle_high));

  assert_underrun_cause_R11: assert property (@(posedge clk) disable iff (rst)
    tx_underrun |-> $past(!tx_valid));

  assert_rx_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && rx_overrun));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind spi_word_engine spi_word_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .busy          (busy),
  .done          (done),
  .sclk          (sclk),
  .cs_n          (cs_n),
  .tx_valid      (tx_valid),
  .tx_underrun   (tx_underrun),
  .rx_valid      (rx_valid),
  .rx_overrun    (rx_overrun),
  .cfg_idle_high (cfg_idle_high)
);

// File: tb/test_spi_word_engine.sv
`timescale 1ns/1ps
module test_spi_word_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_tick = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  cfg_len_m1 = 5'd7;
  logic        cfg_capture_first = 1'b1;
  logic        cfg_loopback = 1'b0;
  logic        cfg_no_tx = 1'b0;
  logic        cfg_no_rx = 1'b0;
  logic        cfg_idle_high = 1'b0;
  logic        cfg_force_cs = 1'b0;
  logic [1:0]  cfg_cs_sel = 2'd0;
  logic [15:0] cfg_word_count = 16'd0;
  logic [31:0] tx_data;
  logic        tx_valid;
  logic        tx_ready;
  logic [31:0] rx_data;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic        tx_underrun, rx_overrun, busy, done, sclk, mosi;
  logic        miso = 1'b0;
  logic [3:0]  cs_n;

  int tests = 0, fails = 0;
  int edges = 0, und_cnt = 0, ovr_cnt = 0, rxv_cnt = 0, hs_cnt = 0;
  bit feed_en = 1'b1;
  bit hs = 1'b0;
  logic prev_sclk = 1'b0;
  string curtag = "R3";
  logic [31:0] txq[$];
  logic [31:0] expq[$];

  always #4 clk = ~clk;

  spi_word_engine i_spi_word_engine (
    .clk(clk), .rst(rst), .spi_tick(spi_tick), .start(start),
    .cfg_len_m1(cfg_len_m1), .cfg_capture_first(cfg_capture_first),
    .cfg_loopback(cfg_loopback), .cfg_no_tx(cfg_no_tx), .cfg_no_rx(cfg_no_rx),
    .cfg_idle_high(cfg_idle_high), .cfg_force_cs(cfg_force_cs),
    .cfg_cs_sel(cfg_cs_sel), .cfg_word_count(cfg_word_count),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_underrun(tx_underrun), .rx_overrun(rx_overrun),
    .busy(busy), .done(done), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n)
  );

  task automatic check_eq(input string rq, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] gen_word(input int seed, input int k);
    return 32'(32'h9E3779B9 * (seed * 8 + k + 1)) ^ 32'h5A0F_C3E1;
  endfunction

  function automatic logic [31:0] rx_expect(input logic [31:0] w, input int n,
                                            input bit lb, input bit notx,
                                            input bit mval);
    logic [31:0] mask;
    mask = (n == 32) ? 32'hFFFF_FFFF : 32'((64'd1 << n) - 64'd1);
    if (lb) return notx ? 32'h0 : (w >> (32 - n));
    return mval ? mask : 32'h0;
  endfunction

  // half-period tick every other cycle
  initial forever begin
    @(negedge clk);
    spi_tick = ~spi_tick;
  end

  // output stream driver: pops a word after each accepted handshake
  initial begin
    logic [31:0] tmp;
    tx_valid = 1'b0;
    tx_data  = 32'h0;
    forever begin
      @(posedge clk);
      #1;
      if (hs) begin
        tmp = txq.pop_front();
        hs_cnt++;
      end
      tx_valid = feed_en && (txq.size() > 0);
      tx_data  = (txq.size() > 0) ? txq[0] : 32'h0;
      @(negedge clk);
      hs = tx_valid && tx_ready;
    end
  end

  // monitor: scoreboard compare and event counters
  initial forever begin
    logic [31:0] e;
    @(negedge clk);
    if (sclk !== prev_sclk) edges++;
    prev_sclk = sclk;
    if (!rst) begin
      if (tx_underrun) und_cnt++;
      if (rx_overrun) ovr_cnt++;
      if (rx_valid) begin
        rxv_cnt++;
        if (expq.size() == 0) begin
          check_eq(curtag, "unexpected rx word", {32'h0, rx_data}, 64'hDEAD);
        end else begin
          e = expq.pop_front();
          check_eq(curtag, "rx word", {32'h0, rx_data}, {32'h0, e});
        end
      end
    end
  end

  task automatic run_xfer(input string rq, input int lenm1, input bit capf,
                          input bit lb, input bit notx, input bit norx,
                          input bit idle, input int sel, input int cnt,
                          input int seed, input bit expect_rx, input bit mval,
                          input int stall);
    int n, und0, guard;
    logic [31:0] w;
    n = (lenm1 < 3) ? 4 : lenm1 + 1;
    curtag = rq;
    @(negedge clk);
    cfg_len_m1 = 5'(lenm1);
    cfg_capture_first = capf;
    cfg_loopback = lb;
    cfg_no_tx = notx;
    cfg_no_rx = norx;
    cfg_idle_high = idle;
    cfg_cs_sel = 2'(sel);
    cfg_word_count = 16'(cnt);
    miso = mval;
    if (stall > 0) feed_en = 1'b0;
    for (int k = 0; k < cnt; k++) begin
      w = gen_word(seed, k);
      if (!notx) txq.push_back(w);
      if (!norx && expect_rx) expq.push_back(rx_expect(w, n, lb, notx, mval));
    end
    repeat (3) @(negedge clk);
    edges = 0;
    und0 = und_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check_eq("R7", "cs_n during transfer", {60'h0, cs_n}, {60'h0, ~(4'b1 << sel)});
    if (stall > 0) begin
      repeat (stall) @(negedge clk);
      check_eq("R11", "underrun pulses", und_cnt - und0, 1);
      check_eq("R11", "sclk edges while stalled", edges, 0);
      check_eq("R11", "sclk idle while stalled", {63'h0, sclk}, {63'h0, idle});
      feed_en = 1'b1;
    end
    guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    check_eq("R8", "done after count", {63'h0, done}, 64'h1);
    check_eq("R8", "busy after count", {63'h0, busy}, 64'h0);
    check_eq("R8", "cs released", {60'h0, cs_n}, 64'hF);
    check_eq("R2", "sclk transitions", edges, 2 * n * cnt);
    check_eq("R6", "sclk idle level", {63'h0, sclk}, {63'h0, idle});
    check_eq(rq, "all expected words seen", expq.size(), 0);
    if (!notx) check_eq(rq, "all output words used", txq.size(), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1", "cs_n", {60'h0, cs_n}, 64'hF);
    check_eq("R1", "sclk", {63'h0, sclk}, 64'h0);
    check_eq("R1", "busy", {63'h0, busy}, 64'h0);
    check_eq("R1", "done", {63'h0, done}, 64'h0);
    check_eq("R1", "rx_valid", {63'h0, rx_valid}, 64'h0);
    check_eq("R1", "tx_ready", {63'h0, tx_ready}, 64'h0);

    // R3: 8-bit loopback, leading-edge capture
    run_xfer("R3", 7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 3, 1, 1'b1, 1'b0, 0);
    // R5: 32-bit loopback, trailing-edge capture, idle high (R6)
    run_xfer("R5", 31, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2, 2, 2, 1'b1, 1'b0, 0);
    // R2: length field below minimum gives 4-bit words
    run_xfer("R2", 1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1, 2, 3, 1'b1, 1'b0, 0);
    // R4: external miso held high, 12 bits, trailing capture
    run_xfer("R4", 11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3, 2, 4, 1'b1, 1'b1, 0);
    // R4: external miso held low, 5 bits, idle high
    run_xfer("R4", 4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0, 1, 5, 1'b1, 1'b0, 0);

    // R9: transmit side off; a waiting word must stay untouched
    begin
      int h0;
      txq.push_back(32'hCAFE_F00D);
      h0 = hs_cnt;
      run_xfer("R9", 15, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1, 2, 6, 1'b1, 1'b0, 0);
      check_eq("R9", "output words consumed", hs_cnt - h0, 0);
      check_eq("R9", "waiting word still queued", txq.size(), 1);
      txq.delete();
      @(negedge clk);
      @(negedge clk);
    end

    // R10: receive side off
    begin
      int r0;
      r0 = rxv_cnt;
      run_xfer("R10", 7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0, 2, 7, 1'b1, 1'b0, 0);
      check_eq("R10", "rx_valid strobes", rxv_cnt - r0, 0);
    end

    // R11: output stream empty at start
    run_xfer("R11", 9, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2, 2, 8, 1'b1, 1'b0, 12);

    // R12: receiver not ready
    begin
      int r0, o0;
      r0 = rxv_cnt;
      o0 = ovr_cnt;
      rx_ready = 1'b0;
      run_xfer("R12", 7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 2, 9, 1'b0, 1'b0, 0);
      check_eq("R12", "overrun pulses", ovr_cnt - o0, 2);
      check_eq("R12", "rx_valid strobes", rxv_cnt - r0, 0);
      rx_ready = 1'b1;
    end

    // R8: zero word count
    @(negedge clk);
    cfg_word_count = 16'd0;
    cfg_idle_high = 1'b0;
    repeat (3) @(negedge clk);
    edges = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check_eq("R8", "zero count done", {63'h0, done}, 64'h1);
    check_eq("R8", "zero count busy", {63'h0, busy}, 64'h0);
    check_eq("R8", "zero count cs_n", {60'h0, cs_n}, 64'hF);
    check_eq("R8", "zero count sclk edges", edges, 0);

    // R7: forced chip select while idle
    cfg_cs_sel = 2'd1;
    cfg_force_cs = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R7", "forced cs_n", {60'h0, cs_n}, 64'hD);
    cfg_force_cs = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R7", "released cs_n", {60'h0, cs_n}, 64'hF);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule